// File: doc/BRIEF.md
# Drive Startup Reset and Stall Latch Supervisor

This block decides, every clock cycle, whether the high-side drivers of a three-phase motor bridge may switch. It combines two digital stand-ins for analog timing networks. The first is a duty-integrating accumulator. It rises by a programmable step while the PWM command is in its active phase and falls by another step while the command is idle. Two hysteretic thresholds move the block between a reset state and an operating state. The second is a stall timer. It is reloaded to full scale in the reset state and by every falling edge of the U-phase high-side signal, and it counts down otherwise.

Once operating, the drivers are enabled only after the stall timer has been seen above an arming level. If the timer then decays to its trip level, a latch holds the drivers off. Only a return to the reset state clears that latch, which happens when the stop input is raised or when the PWM command stays idle long enough. Choose the timeout to span at least two rotation-pulse periods at the slowest expected speed, for example 600 ms for a 300 ms period.

Top module: `drive_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hs_en` is low, the accumulator is zero and the block is in the reset state.
- R2: On each clock edge where `stop_in` is low, the accumulator adds `cfg_inc` and saturates at all-ones if `pwm_in_n` is 0 (active phase). If `pwm_in_n` is 1 it subtracts `cfg_dec` and saturates at zero.
- R3: From the reset state, the block enters the operating state on the edge after the registered accumulator is strictly greater than `cfg_hi`. A value equal to `cfg_hi` does not enter.
- R4: From the operating state, the block returns to reset on the edge after the accumulator is strictly below `cfg_lo`. Values between the thresholds keep the current state.
- R5: `stop_in` high zeroes the accumulator and forces the reset state on the next edge, whatever `pwm_in_n` is.
- R6: In the reset state the stall timer is reloaded to `cfg_stall_full` each cycle, and `hs_en` is low.
- R7: In the operating state the block arms once the stall timer is above `cfg_stall_en`. `hs_en` is high only when the block is operating, armed and not latched. If `cfg_stall_full` <= `cfg_stall_en`, the block never arms.
- R8: While operating, a falling edge of `uh_in` reloads the stall timer to `cfg_stall_full`. A falling edge means the registered copy of `uh_in` is 1 and the current value is 0. Without such an edge the timer counts down by one per cycle and stops at zero.
- R9: When the block is operating and armed and the stall timer is at or below `cfg_stall_trip`, the stall latch sets on the next edge and `hs_en` goes low.
- R10: The stall latch stays set while operating, even when `uh_in` edges resume. It is cleared only by entering the reset state.
- R11: `uh_in` edges while in the reset state have no effect on later behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in_n | input | 1 | PWM command, 0 = active phase |
| stop_in | input | 1 | Stop request, 1 = force reset state |
| uh_in | input | 1 | U-phase high-side drive signal |
| cfg_inc | input | ACC_W | Accumulator step in active phase |
| cfg_dec | input | ACC_W | Accumulator step in idle phase |
| cfg_hi | input | ACC_W | Upper threshold to enter operation |
| cfg_lo | input | ACC_W | Lower threshold to return to reset |
| cfg_stall_full | input | TMR_W | Stall timer reload value |
| cfg_stall_en | input | TMR_W | Arming level of the stall timer |
| cfg_stall_trip | input | TMR_W | Stall trip level |
| hs_en | output | 1 | High-side drive enable |

## Verification
A wrong accumulator value shows up at `hs_en` only as a shifted start or stop. The enable rises two cycles after the accumulator crosses the upper threshold and falls one cycle after it drops below the lower one, so an off-by-one step or a missing saturation moves those edges by whole cycles. A stall timer that reloads or decays wrongly appears as an early or late drop of `hs_en`, exactly `cfg_stall_full - cfg_stall_trip + 1` cycles after the last U-phase falling edge. A latch that clears too easily appears as `hs_en` returning without a pass through reset. The bench therefore compares `hs_en` on every cycle against a cycle model, so any such drift is reported in the cycle it first appears.

// File: rtl/drive_supervisor.sv
module drive_supervisor #(
  parameter int ACC_W = 10,
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in_n,
  input  logic             stop_in,
  input  logic             uh_in,
  input  logic [ACC_W-1:0] cfg_inc,
  input  logic [ACC_W-1:0] cfg_dec,
  input  logic [ACC_W-1:0] cfg_hi,
  input  logic [ACC_W-1:0] cfg_lo,
  input  logic [TMR_W-1:0] cfg_stall_full,
  input  logic [TMR_W-1:0] cfg_stall_en,
  input  logic [TMR_W-1:0] cfg_stall_trip,
  output logic             hs_en
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   acc_sum;
  logic             op_q, op_d;
  logic             uh_q, uh_fall;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             arm_q, lat_q;

  assign acc_sum = {1'b0, acc_q} + {1'b0, cfg_inc};
  assign acc_d = stop_in   ? '0 :
                 !pwm_in_n ? (acc_sum[ACC_W] ? ACC_MAX : acc_sum[ACC_W-1:0]) :
                 (acc_q > cfg_dec) ? acc_q - cfg_dec : '0;
  assign op_d = stop_in ? 1'b0 : op_q ? (acc_q >= cfg_lo) : (acc_q > cfg_hi);

  assign uh_fall = uh_q & ~uh_in;
  assign tmr_d = (!op_q || uh_fall) ? cfg_stall_full :
                 (tmr_q != '0) ? tmr_q - 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      op_q  <= 1'b0;
      uh_q  <= 1'b0;
      tmr_q <= '0;
      arm_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      op_q  <= op_d;
      uh_q  <= uh_in;
      tmr_q <= tmr_d;
      arm_q <= op_q & (arm_q | (tmr_q > cfg_stall_en));
      lat_q <= op_q & (lat_q | (arm_q & (tmr_q <= cfg_stall_trip)));
    end
  end

  assign hs_en = op_q & arm_q & ~lat_q;

  AST_STOP_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_in |=> (acc_q == '0 && !op_q)); // R5
  AST_ENTRY_ABOVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_q) |-> ($past(acc_q) > $past(cfg_hi))); // R3
  AST_RESET_RELOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !op_q |=> (tmr_q == $past(cfg_stall_full))); // R6
  AST_FALL_RELOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && uh_q && !uh_in) |=> (tmr_q == $past(cfg_stall_full))); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && op_q) |=> lat_q); // R10
  AST_TRIP_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && arm_q && tmr_q <= cfg_stall_trip) |=> !hs_en); // R9
endmodule

// File: tb/sim_drive_supervisor.sv
module sim_drive_supervisor;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in_n = 1'b1, stop_in = 1'b0, uh_in = 1'b0;
  logic [AW-1:0] cfg_inc = 4, cfg_dec = 1, cfg_hi = 20, cfg_lo = 8;
  logic [TW-1:0] cfg_stall_full = 40, cfg_stall_en = 30, cfg_stall_trip = 5;
  logic hs_en;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [AW-1:0] m_acc;
  logic m_op, m_uhd, m_arm, m_lat;
  logic [TW-1:0] m_tmr;

  always #(CLK_P/2) clk = ~clk;

  drive_supervisor #(.ACC_W(AW), .TMR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in_n(pwm_in_n), .stop_in(stop_in), .uh_in(uh_in),
    .cfg_inc(cfg_inc), .cfg_dec(cfg_dec), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_stall_full(cfg_stall_full), .cfg_stall_en(cfg_stall_en),
    .cfg_stall_trip(cfg_stall_trip), .hs_en(hs_en));

  function automatic logic [AW-1:0] acc_next(logic [AW-1:0] a, logic on_ph, logic stp);
    int s;
    if (stp) return '0;
    if (on_ph) begin
      s = int'(a) + int'(cfg_inc);
      return (s > (1 << AW) - 1) ? AW'((1 << AW) - 1) : AW'(s);
    end
    return (int'(a) < int'(cfg_dec)) ? '0 : a - cfg_dec;
  endfunction

  function automatic logic exp_en();
    return m_op & m_arm & ~m_lat;
  endfunction

  task automatic model_reset();
    m_acc = '0; m_op = 0; m_uhd = 0; m_tmr = '0; m_arm = 0; m_lat = 0;
  endtask

  task automatic model_step();
    logic [AW-1:0] na; logic nop, narm, nlat; logic [TW-1:0] nt;
    na = acc_next(m_acc, !pwm_in_n, stop_in);
    nop = stop_in ? 1'b0 : (m_op ? (m_acc >= cfg_lo) : (m_acc > cfg_hi));
    if (!m_op || (m_uhd && !uh_in)) nt = cfg_stall_full;
    else nt = (m_tmr == 0) ? '0 : m_tmr - 1;
    narm = m_op && (m_arm || m_tmr > cfg_stall_en);
    nlat = m_op && (m_lat || (m_arm && m_tmr <= cfg_stall_trip));
    m_acc = na; m_op = nop; m_uhd = uh_in; m_tmr = nt; m_arm = narm; m_lat = nlat;
  endtask

  task automatic check(string tag);
    n_chk++;
    if (hs_en !== exp_en()) begin
      n_bad++;
      $display("FAIL %s: hs_en actual %b expected %b at %0t", tag, hs_en, exp_en(), $time);
    end
  endtask

  task automatic cyc(logic pw_n, logic stp, logic uh, string tag);
    pwm_in_n = pw_n; stop_in = stp; uh_in = uh;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic run_uh(int n, int period, string tag);
    for (int i = 0; i < n; i++) cyc(i % 2, 1'b0, ((i / period) % 2) == 0, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R3: accumulator reaching exactly cfg_hi must not enter
    cfg_inc = 4; cfg_dec = 4;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 20; i++) cyc(i % 2 == 0, 1'b0, 1'b0, "R3");
    // R11: uh edges during reset
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, i % 2, "R11");
    cfg_dec = 1;
    // R3, R7: startup and arming
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b0, "R7");
    // R8: rotating keeps drive enabled
    run_uh(200, 8, "R8");
    // R9: stall latches
    for (int i = 0; i < 60; i++) cyc(i % 2, 1'b0, 1'b1, "R9");
    // R10: edges resume, latch holds
    run_uh(100, 5, "R10");
    // R4: idle decay back to reset clears latch
    for (int i = 0; i < 1100; i++) cyc(1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0, "R4");
    run_uh(40, 6, "R8");
    // R5: stop overrides active PWM
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b0, "R5");
    // R7: full not above arming level never arms
    cfg_stall_full = 30;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R7");
    run_uh(60, 4, "R7");
    cfg_stall_full = 40;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R6");
    run_uh(30, 4, "R6");
    // Random phase
    void'($urandom(32'd1234));
    for (int seg = 0; seg < 40; seg++) begin
      cfg_inc = AW'($urandom_range(1, 40));
      cfg_dec = AW'($urandom_range(1, 40));
      cfg_lo = AW'($urandom_range(0, 200));
      cfg_hi = AW'($urandom_range(200, 900));
      cfg_stall_trip = TW'($urandom_range(0, 20));
      cfg_stall_en = TW'($urandom_range(20, 60));
      cfg_stall_full = TW'($urandom_range(15, 120));
      for (int i = 0; i < 600; i++)
        cyc($urandom_range(0, 99) < 30, $urandom_range(0, 999) < 3,
            $urandom_range(0, 99) < (seg % 2 ? 2 : 20) ? ~uh_in : uh_in, "R2");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule